// File: doc/BRIEF.md
# PCI Target Latency Timer Pair

This block supervises how long a PCI target keeps a master waiting. It runs two watchdogs.

The first is an initial-latency timer. It starts when a new transaction's address phase is seen. If the back end has no data ready and the target has not yet responded when the programmed limit runs out, the timer asks the target to retry the access. The limit depends on whether the bus and core clocks are synchronous or asynchronous. Small programmed values are raised to the two-clock floor that PCI target timing imposes anyway.

The second is a subsequent-latency timer. It guards read bursts. After each completed data phase it counts the clocks in which the target holds the bus in a wait state. When that count reaches the programmed limit, it asks the target to start a disconnect.

Both requests are single-clock pulses for the target state machine that drives the bus pins. Every input is a plain active-high level, already synchronised to `clk`: the bus phases, the configuration fields and the back-end readiness. There is no streaming interface and no back-pressure.

Top module: `pci_tgt_lat_timer`

## Requirements
- R1: The clock edge at which `frame_act` is first sampled high while the bus is idle is edge 0. When no retry is suppressed, `retry_req` is high in the cycle that follows edge L, where L is the initial limit.
- R2: With `async_mode` low, L equals `init_dur`.
- R3: With `async_mode` high, L equals `init_dur` plus 14.
- R4: An `init_dur` value of 0 or 1 acts as 2 in both modes, so L is 2 in synchronous mode and 16 in asynchronous mode.
- R5: If `data_ready` is sampled high at any edge from 1 to L, no retry is requested for that transaction.
- R6: If `trdy_act` or `stop_act` is sampled high at any edge from 1 to L, no retry is requested for that transaction.
- R7: While `init_tmr_dis` is high, `retry_req` stays low. A transaction that starts while it is high requests no retry.
- R8: In a read transaction (`is_read` high at edge 0), a data phase completes at an edge where `irdy_act` and `trdy_act` are both sampled high. If `trdy_act` then stays low, `disc_req` is high in the cycle that follows the S-th later edge, where S is `subs_dur`.
- R9: A write transaction (`is_read` low at edge 0) never raises `disc_req`.
- R10: Each completed data phase restarts the wait count. When fewer than S wait-state edges separate consecutive data phases, no disconnect is requested.
- R11: A `subs_dur` value of 0 turns the disconnect request off.
- R12: A synchronous reset (`rst` high at an edge) clears both counters. After that edge both request outputs are low. Each request output is high for at most one clock at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_act | input | 1 | Master framing signal asserted (active-high view) |
| irdy_act | input | 1 | Master ready asserted |
| trdy_act | input | 1 | Target ready asserted |
| stop_act | input | 1 | Target stop asserted |
| is_read | input | 1 | Decoded command is a read, valid with the address phase |
| data_ready | input | 1 | Back end has data for the first transfer |
| init_dur | input | 5 | Initial latency duration field |
| subs_dur | input | 4 | Subsequent latency duration field, 0 disables |
| async_mode | input | 1 | High when the bus and core clocks are asynchronous |
| init_tmr_dis | input | 1 | Disables the initial latency timer |
| retry_req | output | 1 | One-clock request to retry the access |
| disc_req | output | 1 | One-clock request to start a disconnect |

## Verification
The assertions assume legal bus sequencing. The framing signal rises only on an idle bus. The duration fields, mode flag and disable flag stay constant while a transaction is open. Once a wait state begins, the target drives `trdy_act` low until the next data phase. The stimulus ends every transaction by lowering `frame_act` and `irdy_act` together and leaves idle clocks before the next one. It changes configuration only between transactions and holds `irdy_act` high for the whole transaction, so the target alone creates every wait state.

// File: rtl/pci_lat_pkg.sv
package pci_lat_pkg;

  // Initial duration field width and the asynchronous-mode offset
  localparam int unsigned INIT_W    = 5;
  localparam int unsigned SUBS_W    = 4;
  localparam int unsigned ASYNC_ADD = 14;
  localparam int unsigned MIN_INIT  = 2;

  // Bus ownership state seen by the timers
  typedef enum logic {
    BUS_IDLE = 1'b0,
    BUS_BUSY = 1'b1
  } bus_state_e;

endpackage

// File: rtl/lat_init_timer.sv
module lat_init_timer #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic          dis,
  input  logic          resp,
  input  logic          ready,
  input  logic [CW-1:0] limit,
  output logic          retry
);

  logic          run;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      cnt   <= '0;
      lim_q <= '0;
      retry <= 1'b0;
    end else begin
      retry <= 1'b0;
      if (start && !dis) begin
        run   <= 1'b1;
        cnt   <= CW'(1);
        lim_q <= limit;
      end else if (run) begin
        // priority: disable, abort, target response, data ready, limit
        if (dis || abort || resp || ready) begin
          run <= 1'b0;
        end else if (cnt == lim_q) begin
          retry <= 1'b1;
          run   <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/lat_subs_timer.sv
module lat_subs_timer #(
  parameter int unsigned SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          enable,
  input  logic          phase_done,
  input  logic          tgt_wait,
  input  logic [SW-1:0] limit,
  output logic          disc
);

  logic          armed;
  logic [SW-1:0] cnt;
  logic [SW-1:0] cnt_nx;

  assign cnt_nx = cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      armed <= 1'b0;
      cnt   <= '0;
      disc  <= 1'b0;
    end else begin
      disc <= 1'b0;
      if (phase_done && enable && (limit != '0)) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (armed && tgt_wait) begin
        cnt <= cnt_nx;
        if (cnt_nx == limit) begin
          disc  <= 1'b1;
          armed <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pci_tgt_lat_timer.sv
module pci_tgt_lat_timer
  import pci_lat_pkg::*;
#(
  parameter int unsigned IW   = INIT_W,
  parameter int unsigned SW   = SUBS_W,
  parameter int unsigned AOFS = ASYNC_ADD,
  parameter int unsigned MINL = MIN_INIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_act,
  input  logic          irdy_act,
  input  logic          trdy_act,
  input  logic          stop_act,
  input  logic          is_read,
  input  logic          data_ready,
  input  logic [IW-1:0] init_dur,
  input  logic [SW-1:0] subs_dur,
  input  logic          async_mode,
  input  logic          init_tmr_dis,
  output logic          retry_req,
  output logic          disc_req
);

  localparam int unsigned MAXL = (1 << IW) - 1 + AOFS;
  localparam int unsigned CW   = $clog2(MAXL + 1);

  bus_state_e    bus_q;
  logic          rd_q;
  logic          start;
  logic          txn_end;
  logic [CW-1:0] base_lim;
  logic [CW-1:0] init_lim;

  assign start   = frame_act && (bus_q == BUS_IDLE);
  assign txn_end = (bus_q == BUS_BUSY) && !frame_act && !irdy_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= BUS_IDLE;
      rd_q  <= 1'b0;
    end else if (start) begin
      bus_q <= BUS_BUSY;
      rd_q  <= is_read;
    end else if (txn_end) begin
      bus_q <= BUS_IDLE;
      rd_q  <= 1'b0;
    end
  end

  // clamp to the two-clock floor, then add the mode offset
  always_comb begin
    base_lim = CW'(init_dur);
    if (init_dur < IW'(MINL)) base_lim = CW'(MINL);
    init_lim = async_mode ? (base_lim + CW'(AOFS)) : base_lim;
  end

  lat_init_timer #(.CW(CW)) u_init (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .abort (txn_end),
    .dis   (init_tmr_dis),
    .resp  (trdy_act || stop_act),
    .ready (data_ready),
    .limit (init_lim),
    .retry (retry_req)
  );

  lat_subs_timer #(.SW(SW)) u_subs (
    .clk        (clk),
    .rst        (rst),
    .clear      (txn_end),
    .enable     (rd_q),
    .phase_done (irdy_act && trdy_act),
    .tgt_wait   (!trdy_act),
    .limit      (subs_dur),
    .disc       (disc_req)
  );

endmodule

// File: rtl/pci_tgt_lat_timer_chk.sv
module pci_tgt_lat_timer_chk (
  input logic clk,
  input logic rst,
  input logic trdy_act,
  input logic data_ready,
  input logic init_tmr_dis,
  input logic retry_req,
  input logic disc_req
);

  // R12: single-clock request pulses
  a_r12_retry_pulse: assert property (@(posedge clk) disable iff (rst)
    retry_req |=> !retry_req);
  a_r12_disc_pulse: assert property (@(posedge clk) disable iff (rst)
    disc_req |=> !disc_req);

  // R12: reset edge leaves both requests low
  a_r12_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!retry_req && !disc_req));

  // R7: no retry issued from an edge with the timer disabled
  a_r7_dis_blocks: assert property (@(posedge clk) disable iff (rst)
    retry_req |-> !$past(init_tmr_dis));

  // R5: ready data at the decision edge forbids a retry
  a_r5_ready_blocks: assert property (@(posedge clk) disable iff (rst)
    retry_req |-> !$past(data_ready));

  // R8: a disconnect follows a target wait state only
  a_r8_disc_on_wait: assert property (@(posedge clk) disable iff (rst)
    disc_req |-> !$past(trdy_act));

endmodule

bind pci_tgt_lat_timer pci_tgt_lat_timer_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .trdy_act     (trdy_act),
  .data_ready   (data_ready),
  .init_tmr_dis (init_tmr_dis),
  .retry_req    (retry_req),
  .disc_req     (disc_req)
);

// File: tb/tb_pci_tgt_lat_timer.sv
module tb_pci_tgt_lat_timer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_act = 1'b0, irdy_act = 1'b0, trdy_act = 1'b0, stop_act = 1'b0;
  logic       is_read = 1'b0, data_ready = 1'b0;
  logic [4:0] init_dur = 5'd0;
  logic [3:0] subs_dur = 4'd0;
  logic       async_mode = 1'b0, init_tmr_dis = 1'b0;
  logic       retry_req, disc_req;

  typedef struct {
    int    cyc;
    string tag;
  } exp_t;

  exp_t  qr[$];
  exp_t  qd[$];
  int    cyc = 0;
  int    n_tests = 0;
  int    n_fail = 0;
  string cur_tag = "R12";

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  pci_tgt_lat_timer dut (
    .clk(clk), .rst(rst), .frame_act(frame_act), .irdy_act(irdy_act),
    .trdy_act(trdy_act), .stop_act(stop_act), .is_read(is_read),
    .data_ready(data_ready), .init_dur(init_dur), .subs_dur(subs_dur),
    .async_mode(async_mode), .init_tmr_dis(init_tmr_dis),
    .retry_req(retry_req), .disc_req(disc_req)
  );

  // monitor: compare outputs against the expected-event queues
  always @(negedge clk) if (!rst) begin
    if (qr.size() > 0 && qr[0].cyc < cyc) begin
      n_tests++; n_fail++;
      $display("FAIL %s retry missing: actual 0 expected 1 at cycle %0d", qr[0].tag, qr[0].cyc);
      void'(qr.pop_front());
    end
    if (qr.size() > 0 && qr[0].cyc == cyc) begin
      n_tests++;
      if (!retry_req) begin
        n_fail++;
        $display("FAIL %s retry_req: actual %0b expected 1 at cycle %0d", qr[0].tag, retry_req, cyc);
      end
      void'(qr.pop_front());
    end else if (retry_req) begin
      n_tests++; n_fail++;
      $display("FAIL %s retry_req: actual 1 expected 0 at cycle %0d", cur_tag, cyc);
    end
    if (qd.size() > 0 && qd[0].cyc < cyc) begin
      n_tests++; n_fail++;
      $display("FAIL %s disc missing: actual 0 expected 1 at cycle %0d", qd[0].tag, qd[0].cyc);
      void'(qd.pop_front());
    end
    if (qd.size() > 0 && qd[0].cyc == cyc) begin
      n_tests++;
      if (!disc_req) begin
        n_fail++;
        $display("FAIL %s disc_req: actual %0b expected 1 at cycle %0d", qd[0].tag, disc_req, cyc);
      end
      void'(qd.pop_front());
    end else if (disc_req) begin
      n_tests++; n_fail++;
      $display("FAIL %s disc_req: actual 1 expected 0 at cycle %0d", cur_tag, cyc);
    end
  end

  task automatic end_txn();
    @(negedge clk);
    frame_act = 0; irdy_act = 0; trdy_act = 0; stop_act = 0; data_ready = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic quiet_check(string tag);
    // counts a window that must show no request; the monitor flags any pulse
    n_tests++;
    if (qr.size() != 0 || qd.size() != 0) begin
      n_fail++;
      $display("FAIL %s pending events: actual %0d expected 0", tag, qr.size() + qd.size());
    end
  endtask

  // initial-latency case; ready_at / resp_at are clocks after start, 0 = never
  task automatic init_case(int dur, bit am, bit dis, int ready_at, int resp_at, string tag);
    int  lim;
    bit  exp_r;
    int  base;
    @(negedge clk);
    cur_tag = tag;
    init_dur = 5'(dur); async_mode = am; init_tmr_dis = dis; subs_dur = 4'd0;
    frame_act = 1; irdy_act = 1; is_read = 1; data_ready = 0; trdy_act = 0; stop_act = 0;
    base = cyc;
    lim = ((dur < 2) ? 2 : dur) + (am ? 14 : 0);
    exp_r = !dis && (ready_at == 0 || ready_at > lim) && (resp_at == 0 || resp_at > lim);
    if (exp_r) qr.push_back('{base + 1 + lim, tag});
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      data_ready = (ready_at != 0 && k >= ready_at);
      stop_act   = (resp_at != 0 && k == resp_at);
    end
    end_txn();
    if (!exp_r) quiet_check(tag);
  endtask

  // subsequent-latency case; gap = clocks between data phases, 0 = stall after first
  task automatic subs_case(int sd, bit rd, int gap, int nph, string tag);
    int d;
    @(negedge clk);
    cur_tag = tag;
    init_dur = 5'd31; async_mode = 0; init_tmr_dis = 0; subs_dur = 4'(sd);
    frame_act = 1; irdy_act = 1; is_read = rd; data_ready = 1; trdy_act = 0; stop_act = 0;
    @(negedge clk);
    @(negedge clk);
    trdy_act = 1;
    d = cyc + 1;
    @(negedge clk);
    trdy_act = 0;
    if (gap == 0) begin
      if (rd && sd != 0) qd.push_back('{d + sd, tag});
      repeat (40) @(negedge clk);
    end else begin
      for (int p = 1; p < nph; p++) begin
        repeat (gap - 1) @(negedge clk);
        trdy_act = 1;
        @(negedge clk);
        trdy_act = 0;
      end
    end
    frame_act = 0; irdy_act = 0; data_ready = 0;
    repeat (3) @(negedge clk);
    if (!(gap == 0 && rd && sd != 0)) quiet_check(tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: outputs low during reset
    n_tests++;
    if (retry_req !== 1'b0 || disc_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 reset outputs: actual %0b%0b expected 00", retry_req, disc_req);
    end
    rst = 0;
    repeat (2) @(negedge clk);

    init_case(5,  0, 0, 0, 0, "R1_R2_sync5");
    init_case(31, 0, 0, 0, 0, "R2_sync31");
    init_case(0,  0, 0, 0, 0, "R4_sync0");
    init_case(1,  0, 0, 0, 0, "R4_sync1");
    init_case(3,  1, 0, 0, 0, "R3_async3");
    init_case(0,  1, 0, 0, 0, "R4_async0");
    init_case(31, 1, 0, 0, 0, "R3_async31");
    init_case(6,  0, 0, 6, 0, "R5_ready_at_limit");
    init_case(6,  0, 0, 7, 0, "R5_ready_late");
    init_case(8,  0, 0, 0, 3, "R6_stop_early");
    init_case(4,  0, 1, 0, 0, "R7_disabled");
    subs_case(4,  1, 0, 1, "R8_read_stall4");
    subs_case(15, 1, 0, 1, "R8_read_stall15");
    subs_case(2,  0, 0, 1, "R9_write_stall");
    subs_case(3,  1, 3, 5, "R10_gap_restart");
    subs_case(0,  1, 0, 1, "R11_zero_off");

    // R12: reset in the middle of a counting transaction clears everything
    @(negedge clk);
    cur_tag = "R12_mid_reset";
    init_dur = 5'd4; async_mode = 0; init_tmr_dis = 0;
    frame_act = 1; irdy_act = 1; is_read = 1; data_ready = 0;
    repeat (2) @(negedge clk);
    rst = 1;
    @(negedge clk);
    n_tests++;
    if (retry_req !== 1'b0 || disc_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R12 after reset: actual %0b%0b expected 00", retry_req, disc_req);
    end
    frame_act = 0; irdy_act = 0;
    @(negedge clk);
    rst = 0;
    repeat (10) @(negedge clk);
    quiet_check("R12_mid_reset");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule